// File: doc/BRIEF.md
# Per-Queue Interrupt Source Selector

This block turns the status flags of a set of hardware queues into two interrupt lines. The queue set is split into a lower half and an upper half. Each lower-half queue has a programmable 3-bit source code. The code picks one of the queue's four status flags and can invert it. Every upper-half queue has one fixed source: its nearly-empty flag, inverted, which means "not nearly empty".

A rising edge of a queue's condition, seen while that queue is enabled, latches a bit in its half's status register. Software clears these bits by writing ones. Each half drives its own interrupt line, which is high while any status bit of that half is set and enabled. The FIFO storage is elsewhere; its flags arrive here as input vectors.

All registers sit behind one simple write/read port. With the default of 32 queues per half, the addresses are:

| Address | Register |
|---|---|
| 0..3 | Lower-half source codes |
| 4 | Lower-half enable |
| 5 | Upper-half enable |
| 6 | Lower-half status |
| 7 | Upper-half status |

Top module: `qirq_selector`

## Requirements
- R1: After reset, every register reads zero, and both interrupt lines stay low until a register is written.
- R2: Source-code registers hold eight queues each. Queue q uses nibble q%8 of register q/8, with bits [2:0] stored and bit 3 reserved. A write of all ones therefore reads back as 0x77777777.
- R3: For a lower-half queue, bits [1:0] of its code pick one flag from lo_flags[4q+3:4q]. The flags are 0 = empty, 1 = nearly empty, 2 = nearly full, 3 = full. Flags that are not selected have no effect.
- R4: Bit 2 of the code inverts the selected flag before edge detection.
- R5: An upper-half queue's condition is the inverse of its hi_nempty bit. Its status bit is set on a falling edge of that input and never on a rising edge.
- R6: A queue whose enable bit is zero never sets its status bit.
- R7: Status bits latch on a 0-to-1 change of the condition only. A condition held high does not set the bit again after it is cleared.
- R8: Writing to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: A set event in the same cycle as a clear of the same bit leaves the bit set.
- R10: Each interrupt line is the OR over its half of status AND enable. Clearing an enable drops the line without touching the status bit, and setting the enable again raises the line.
- R11: The lower half drives only irq_lo and the upper half drives only irq_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_flags | input | 4*HALF_Q | Four status flags per lower-half queue |
| hi_nempty | input | HALF_Q | Nearly-empty flag per upper-half queue |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_lo | output | 1 | Lower-half interrupt |
| irq_hi | output | 1 | Upper-half interrupt |

## Verification
A software clear of the status register can land in the same cycle as a new rising edge of the same queue's condition. The bench provokes this by driving the flag change and the write-one-to-clear on the same falling clock edge, so both take effect at the next rising edge. It then reads the status back and expects the bit still set, with the interrupt line high. A second collision is a source-code rewrite that coincides with a flag change. The sweep avoids it by holding the enable low while a code is reprogrammed.

// File: rtl/qirq_selector.sv
module qirq_selector #(
  parameter int HALF_Q = 32,
  localparam int NSRC = HALF_Q / 8,
  localparam int AW = $clog2(NSRC + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4*HALF_Q-1:0] lo_flags,
  input  logic [HALF_Q-1:0] hi_nempty,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam logic [AW-1:0] A_EN_LO = AW'(NSRC);
  localparam logic [AW-1:0] A_EN_HI = AW'(NSRC + 1);
  localparam logic [AW-1:0] A_ST_LO = AW'(NSRC + 2);
  localparam logic [AW-1:0] A_ST_HI = AW'(NSRC + 3);

  logic [2:0]        src [HALF_Q];
  logic [HALF_Q-1:0] cond_lo, cond_hi, cond_lo_q, cond_hi_q;
  logic [HALF_Q-1:0] en_lo, en_hi, st_lo, st_hi;
  logic [HALF_Q-1:0] set_lo, set_hi, clr_lo, clr_hi;
  logic [7:0]        unused_rsv;

  for (genvar q = 0; q < HALF_Q; q++) begin : g_q
    logic [3:0] fl;
    assign fl = lo_flags[4*q +: 4];
    assign cond_lo[q] = fl[src[q][1:0]] ^ src[q][2];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) src[q] <= '0;
      else if (reg_we && reg_addr == AW'(q / 8)) src[q] <= reg_wdata[4*(q%8) +: 3];
  end

  for (genvar i = 0; i < 8; i++) begin : g_rsv
    assign unused_rsv[i] = reg_wdata[4*i+3];
  end

  assign cond_hi = ~hi_nempty;
  assign set_lo  = cond_lo & ~cond_lo_q & en_lo;
  assign set_hi  = cond_hi & ~cond_hi_q & en_hi;
  assign clr_lo  = (reg_we && reg_addr == A_ST_LO) ? reg_wdata[HALF_Q-1:0] : '0;
  assign clr_hi  = (reg_we && reg_addr == A_ST_HI) ? reg_wdata[HALF_Q-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_lo_q <= '0;
      cond_hi_q <= '0;
      en_lo     <= '0;
      en_hi     <= '0;
      st_lo     <= '0;
      st_hi     <= '0;
    end else begin
      cond_lo_q <= cond_lo;
      cond_hi_q <= cond_hi;
      if (reg_we && reg_addr == A_EN_LO) en_lo <= reg_wdata[HALF_Q-1:0];
      if (reg_we && reg_addr == A_EN_HI) en_hi <= reg_wdata[HALF_Q-1:0];
      st_lo <= (st_lo & ~clr_lo) | set_lo;
      st_hi <= (st_hi & ~clr_hi) | set_hi;
    end
  end

  assign irq_lo = |(st_lo & en_lo);
  assign irq_hi = |(st_hi & en_hi);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN_LO: reg_rdata[HALF_Q-1:0] = en_lo;
      A_EN_HI: reg_rdata[HALF_Q-1:0] = en_hi;
      A_ST_LO: reg_rdata[HALF_Q-1:0] = st_lo;
      A_ST_HI: reg_rdata[HALF_Q-1:0] = st_hi;
      default:
        for (int q = 0; q < HALF_Q; q++)
          if (reg_addr == AW'(q / 8)) reg_rdata[4*(q%8) +: 3] = src[q];
    endcase
  end
endmodule

module qirq_selector_chk #(
  parameter int HALF_Q = 32,
  localparam int NSRC = HALF_Q / 8,
  localparam int AW = $clog2(NSRC + 4)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4*HALF_Q-1:0] lo_flags,
  input logic [HALF_Q-1:0] hi_nempty,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq_lo,
  input logic              irq_hi
);
  logic any_wr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) any_wr <= 1'b0;
    else if (reg_we) any_wr <= 1'b1;

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |-> (!irq_lo && !irq_hi));

  // R10
  irq_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && !reg_we) |=> irq_lo);

  // R8
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && reg_we && reg_addr == AW'(NSRC + 2) && reg_wdata == '0) |=> irq_lo);

  // R3
  lo_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lo) |-> ($past(reg_we) || $past(reg_we, 2) ||
                       ($past(lo_flags) != $past(lo_flags, 2))));

  // R5
  hi_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_hi) |-> ($past(reg_we) || (|($past(hi_nempty, 2) & ~$past(hi_nempty)))));
endmodule

bind qirq_selector qirq_selector_chk #(.HALF_Q(HALF_Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_flags(lo_flags), .hi_nempty(hi_nempty),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_lo(irq_lo), .irq_hi(irq_hi));

// File: tb/qirq_selector_bench.sv
module qirq_selector_bench;
  localparam int HQ = 32;
  localparam int AW = 3;
  localparam logic [AW-1:0] EN_LO = 4, EN_HI = 5, ST_LO = 6, ST_HI = 7;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [4*HQ-1:0] lo_flags = '0;
  logic [HQ-1:0]   hi_nempty = '0;
  logic [AW-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0, rd_v;
  logic [31:0]     reg_rdata;
  logic irq_lo, irq_hi;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qirq_selector u_qirq_selector (
    .clk(clk), .rst_n(rst_n), .lo_flags(lo_flags), .hi_nempty(hi_nempty),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); reg_addr = a; #1 rd_v = reg_rdata;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a)); check("R1 reg zero", rd_v, 0);
    end
    check("R1 irq low", {30'd0, irq_hi, irq_lo}, 0);

    // R2 reserved bits
    wr(0, 32'hFFFF_FFFF); rd(0); check("R2 src readback", rd_v, 32'h7777_7777);
    wr(3, 32'h8A5C_3F12); rd(3); check("R2 src readback", rd_v, 32'h0254_3712);
    for (int r = 0; r < 4; r++) wr(AW'(r), 0);

    // R3/R4 sweep of all lower queues and all codes
    for (int q = 0; q < HQ; q++) begin
      for (int c = 0; c < 8; c++) begin
        int b; logic inv;
        b = c & 3; inv = c[2];
        wr(EN_LO, 0);
        @(negedge clk); lo_flags = {4*HQ{inv}};
        wr(AW'(q / 8), 32'(c) << (4 * (q % 8)));
        wr(ST_LO, 32'hFFFF_FFFF);
        wr(EN_LO, 32'd1 << q);
        @(negedge clk); lo_flags[4*q + ((b + 1) % 4)] = ~inv;
        rd(ST_LO); check("R3 unselected flag ignored", rd_v, 0);
        @(negedge clk); lo_flags[4*q + b] = ~inv;
        rd(ST_LO); check(c[2] ? "R4 inverted source" : "R3 selected source", rd_v, 32'd1 << q);
        check("R11 irq_lo only", {30'd0, irq_hi, irq_lo}, 1);
      end
    end

    // R7 held condition after clear
    wr(ST_LO, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    rd(ST_LO); check("R7 level no reset", rd_v, 0);

    // R6 disabled queue
    wr(EN_LO, 0); wr(0, 0);
    @(negedge clk); lo_flags = '0;
    repeat (2) @(negedge clk);
    wr(ST_LO, 32'hFFFF_FFFF);
    @(negedge clk); lo_flags[0] = 1;
    rd(ST_LO); check("R6 disabled no set", rd_v, 0);
    check("R6 irq low", {31'd0, irq_lo}, 0);

    // R8 W1C
    wr(EN_LO, 32'h0000_0003); wr(1, 0);
    @(negedge clk); lo_flags[0] = 0; lo_flags[4] = 0;
    @(negedge clk); lo_flags[0] = 1; lo_flags[4] = 1;
    rd(ST_LO); check("R8 both set", rd_v, 3);
    wr(ST_LO, 0); rd(ST_LO); check("R8 zero write keeps", rd_v, 3);
    wr(ST_LO, 1); rd(ST_LO); check("R8 one clears", rd_v, 2);

    // R10 enable masking
    wr(EN_LO, 1); check("R10 masked irq low", {31'd0, irq_lo}, 0);
    rd(ST_LO); check("R10 status kept", rd_v, 2);
    wr(EN_LO, 2); check("R10 unmasked irq high", {31'd0, irq_lo}, 1);
    wr(ST_LO, 2); check("R10 cleared irq low", {31'd0, irq_lo}, 0);

    // R9 set beats clear in the same cycle
    wr(EN_LO, 1);
    @(negedge clk); lo_flags[0] = 0;
    @(negedge clk);
    lo_flags[0] = 1; reg_we = 1; reg_addr = ST_LO; reg_wdata = 1;
    @(negedge clk); reg_we = 0;
    rd(ST_LO); check("R9 set wins", rd_v, 1);
    check("R9 irq high", {31'd0, irq_lo}, 1);
    wr(ST_LO, 32'hFFFF_FFFF); wr(EN_LO, 0);

    // R5 upper half fixed source
    @(negedge clk); hi_nempty = '1;
    repeat (2) @(negedge clk);
    for (int q = 0; q < HQ; q++) begin
      wr(ST_HI, 32'hFFFF_FFFF);
      wr(EN_HI, 32'd1 << q);
      @(negedge clk); hi_nempty[q] = 0;
      rd(ST_HI); check("R5 falling sets", rd_v, 32'd1 << q);
      check("R11 irq_hi only", {30'd0, irq_hi, irq_lo}, 2);
      wr(ST_HI, 32'hFFFF_FFFF);
      @(negedge clk); hi_nempty[q] = 1;
      rd(ST_HI); check("R5 rising ignored", rd_v, 0);
    end

    summary();
  end
endmodule